// File: doc/BRIEF.md
# Two-Port Memory with Same-Word Contention Arbitration

This block is a single-clock model of a static memory that two independent ports can read and write at the same time. Each port has an active-low enable, a read/write select (high reads, low writes), an active-low output enable, an address, write data, registered read data and an active-low BUSY flag. When both enabled ports point at the same word, the block picks one port as the owner of that word. It raises BUSY toward the other port and keeps that port's writes from landing.

Ownership goes to the port that was already sitting on the word: a port that was enabled on the same address in the previous clock beats a port that just arrived. If neither port led by a clock, port A wins. A write is committed when its request ends, which is the clock in which enable or read/write returns high. The losing port's read data stays frozen while it keeps losing on the same address in the same read mode. The data is refreshed once its BUSY clears, its address moves, its enable toggles or its read/write toggles.

Top module: `dpram_contend`

## Requirements
- R1: A write request (enable low and read/write low) is committed to memory in the clock where the request ends, using the address and data seen in its last requesting clock. If both ports commit to the same word in one clock, port A's data stays.
- R2: Read data is registered. A reading port's output shows, one clock after the address, the word as it stood before any write committed at that same edge.
- R3: BUSY is registered and is driven low toward one port only. It is low in the clock after a clock in which both enables were low with equal addresses and that port lost the word. The owning port always sees BUSY high.
- R4: Both BUSY outputs are high in the clock after any clock in which the addresses differ or either enable is high.
- R5: When contention begins, a port that was enabled on the same address in the previous clock wins over one that was not. With no such leader, port A wins. The owner is kept for as long as the contention lasts without a break.
- R6: A write request made while the port loses the word is dropped and never reaches memory, even after the contention ends.
- R7: A losing port that was also losing in the previous clock, with the same address and reading in both clocks, keeps its read data unchanged. The data is refreshed as soon as BUSY clears, the address changes, the enable toggles or read/write toggles.
- R8: A high output enable forces that port's read data output to zero without changing what it holds.
- R9: After reset, both BUSY outputs are high, both read data outputs are zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_ce_n | input | 1 | Port A enable, active low |
| a_rw_n | input | 1 | Port A read (1) or write (0) |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_busy_n | output | 1 | Port A contention flag, active low |
| b_ce_n | input | 1 | Port B enable, active low |
| b_rw_n | input | 1 | Port B read (1) or write (0) |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_busy_n | output | 1 | Port B contention flag, active low |

## Verification
The bench goes after the arbitration cases where the leader is decided: one port already settled on the word, both arriving in the same clock, and a port returning to a word the other still holds. A design with the wrong tie-break or no memory of who arrived first would flag the wrong port. It drives a losing port that tries to write and later reads the word back. Letting that write through would leave the losing data in memory. It freezes a loser's read output while the owner commits a new value, then releases the hold with a read/write toggle. A design that refreshes too early or never refreshes shows a different byte at that point. Random collisions on four shared words are compared clock by clock against a model built from the requirements.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

    localparam int DEF_ADDR_W = 10;
    localparam int DEF_DATA_W = 8;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // Owner for a fresh contention: the settled side leads, A breaks ties.
    function automatic side_e pick_leader(input logic lead_a, input logic lead_b);
        return (lead_b && !lead_a) ? SIDE_B : SIDE_A;
    endfunction

endpackage

// File: rtl/dpram_array.sv
`timescale 1ns/1ps
module dpram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_q_a,
    output logic [DATA_W-1:0] rd_q_b,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] wr_addr_a,
    input  logic [DATA_W-1:0] wr_data_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] wr_addr_b,
    input  logic [DATA_W-1:0] wr_data_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    assign rd_q_a = cells[rd_addr_a];
    assign rd_q_b = cells[rd_addr_b];

    // Port A is applied last so that it wins a same-word commit.
    always_ff @(posedge clk) begin
        if (we_b) cells[wr_addr_b] <= wr_data_b;
        if (we_a) cells[wr_addr_a] <= wr_data_a;
    end

endmodule

// File: rtl/dpram_arbiter.sv
`timescale 1ns/1ps
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_a,
    input  logic              act_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              settled_a,
    input  logic              settled_b,
    output logic              loser_a,
    output logic              loser_b,
    output logic              busy_a_n,
    output logic              busy_b_n
);
    logic  hit;
    logic  hit_q;
    side_e own;
    side_e own_q;

    assign hit = act_a && act_b && (addr_a == addr_b);

    always_comb begin
        if (hit && hit_q) own = own_q;
        else              own = pick_leader(settled_a, settled_b);
    end

    assign loser_a = hit && (own == SIDE_B);
    assign loser_b = hit && (own == SIDE_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q    <= 1'b0;
            own_q    <= SIDE_A;
            busy_a_n <= 1'b1;
            busy_b_n <= 1'b1;
        end else begin
            hit_q    <= hit;
            own_q    <= own;
            busy_a_n <= !loser_a;
            busy_b_n <= !loser_b;
        end
    end

    AST_OWNER_KEPT_A: assert property (@(posedge clk) disable iff (rst)
        (hit && own == SIDE_A) ##1 hit |-> own == SIDE_A); // R5
    AST_OWNER_KEPT_B: assert property (@(posedge clk) disable iff (rst)
        (hit && own == SIDE_B) ##1 hit |-> own == SIDE_B); // R5

endmodule

// File: rtl/dpram_port.sv
`timescale 1ns/1ps
module dpram_port #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              loser,
    input  logic [DATA_W-1:0] mem_q,
    output logic              settled,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rdata
);
    logic              ce_n_q;
    logic              rw_n_q;
    logic [ADDR_W-1:0] addr_q;
    logic              loser_q;
    logic              pend;
    logic [DATA_W-1:0] rdata_q;
    logic              wreq;
    logic              rreq;
    logic              hold;

    assign wreq    = !ce_n && !rw_n;
    assign rreq    = !ce_n && rw_n;
    assign settled = !ce_n && !ce_n_q && (addr == addr_q);

    // Frozen only while losing twice in a row on one word in read mode.
    assign hold = loser && loser_q && !ce_n_q && (addr == addr_q) && rw_n && rw_n_q;

    // Commit when the request ends; a blocked request cleared pend earlier.
    assign wr_en = pend && !wreq;
    assign rdata = oe_n ? '0 : rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n_q  <= 1'b1;
            rw_n_q  <= 1'b1;
            addr_q  <= '0;
            loser_q <= 1'b0;
            pend    <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rdata_q <= '0;
        end else begin
            ce_n_q  <= ce_n;
            rw_n_q  <= rw_n;
            addr_q  <= addr;
            loser_q <= loser;
            pend    <= wreq && !loser;
            if (wreq && !loser) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
            if (rreq && !hold) rdata_q <= mem_q;
        end
    end

    AST_COMMIT_GRANTED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!ce_n && !rw_n && !loser)); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(rdata_q)); // R7

endmodule

// File: rtl/dpram_contend.sv
`timescale 1ns/1ps
module dpram_contend
    import dpram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_ce_n,
    input  logic              a_rw_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_busy_n,
    input  logic              b_ce_n,
    input  logic              b_rw_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_busy_n
);
    logic              settled_a, settled_b;
    logic              loser_a, loser_b;
    logic              we_a, we_b;
    logic [ADDR_W-1:0] wa_a, wa_b;
    logic [DATA_W-1:0] wd_a, wd_b;
    logic [DATA_W-1:0] q_a, q_b;

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst(rst),
        .act_a(!a_ce_n), .act_b(!b_ce_n),
        .addr_a(a_addr), .addr_b(b_addr),
        .settled_a(settled_a), .settled_b(settled_b),
        .loser_a(loser_a), .loser_b(loser_b),
        .busy_a_n(a_busy_n), .busy_b_n(b_busy_n)
    );

    dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
        .clk(clk), .rst(rst),
        .ce_n(a_ce_n), .rw_n(a_rw_n), .oe_n(a_oe_n),
        .addr(a_addr), .wdata(a_wdata),
        .loser(loser_a), .mem_q(q_a),
        .settled(settled_a), .wr_en(we_a), .wr_addr(wa_a), .wr_data(wd_a),
        .rdata(a_rdata)
    );

    dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
        .clk(clk), .rst(rst),
        .ce_n(b_ce_n), .rw_n(b_rw_n), .oe_n(b_oe_n),
        .addr(b_addr), .wdata(b_wdata),
        .loser(loser_b), .mem_q(q_b),
        .settled(settled_b), .wr_en(we_b), .wr_addr(wa_b), .wr_data(wd_b),
        .rdata(b_rdata)
    );

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk),
        .rd_addr_a(a_addr), .rd_addr_b(b_addr),
        .rd_q_a(q_a), .rd_q_b(q_b),
        .we_a(we_a), .wr_addr_a(wa_a), .wr_data_a(wd_a),
        .we_b(we_b), .wr_addr_b(wa_b), .wr_data_b(wd_b)
    );

    AST_BUSY_CAUSE_A: assert property (@(posedge clk) disable iff (rst)
        !a_busy_n |-> $past(!a_ce_n && !b_ce_n && a_addr == b_addr)); // R3
    AST_BUSY_CAUSE_B: assert property (@(posedge clk) disable iff (rst)
        !b_busy_n |-> $past(!a_ce_n && !b_ce_n && a_addr == b_addr)); // R3
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        a_busy_n || b_busy_n); // R3
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (a_ce_n || b_ce_n || a_addr != b_addr) |=> (a_busy_n && b_busy_n)); // R4

endmodule

// File: tb/dpram_contend_test.sv
`timescale 1ns/1ps
module dpram_contend_test;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int NV = 14;
    localparam int NRAND = 600;

    // {a_ce_n, a_rw_n, a_addr[1:0], b_ce_n, b_rw_n, b_addr[1:0], exp_a_busy_n, exp_b_busy_n}
    localparam logic [9:0] VEC [NV] = '{
        10'b11_00_11_00_11, 10'b01_00_11_00_11, 10'b01_00_01_00_10, 10'b01_00_01_00_10,
        10'b01_00_01_01_11, 10'b01_01_01_01_01, 10'b11_01_01_01_11, 10'b01_10_01_10_10,
        10'b01_10_11_10_11, 10'b01_10_01_10_10, 10'b11_00_11_00_11, 10'b00_11_00_11_10,
        10'b11_11_00_11_11, 10'b11_11_11_11_11
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          ce [2];
    logic          rw [2];
    logic          oe [2];
    logic [AW-1:0] ad [2];
    logic [DW-1:0] wd [2];
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_busy_n, b_busy_n;

    dpram_contend #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .a_ce_n(ce[0]), .a_rw_n(rw[0]), .a_oe_n(oe[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
        .a_rdata(a_rdata), .a_busy_n(a_busy_n),
        .b_ce_n(ce[1]), .b_rw_n(rw[1]), .b_oe_n(oe[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
        .b_rdata(b_rdata), .b_busy_n(b_busy_n)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // Reference model state, built from the requirements.
    logic [DW-1:0] mm [1024];
    bit   [1023:0] kn;
    bit            hitq, ownq;
    bit            ceq [2], rwq [2], lq [2], pd [2], rk [2], bz [2];
    logic [AW-1:0] adq [2], pa [2];
    logic [DW-1:0] pdat [2], rq [2];

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        hitq = 0; ownq = 0; kn = '0;
        for (int i = 0; i < 2; i++) begin
            ceq[i] = 1; rwq[i] = 1; adq[i] = '0; lq[i] = 0; pd[i] = 0;
            pa[i] = '0; pdat[i] = '0; rq[i] = '0; rk[i] = 1; bz[i] = 1;
        end
    endtask

    task automatic tick(input string tag);
        bit act [2], setl [2], los [2], wreq [2], rreq [2], hold [2], wr [2], nk [2];
        bit hit, own;
        logic [DW-1:0] nr [2];
        for (int i = 0; i < 2; i++) begin
            act[i]  = !ce[i];
            setl[i] = act[i] && !ceq[i] && (ad[i] == adq[i]);
        end
        hit = act[0] && act[1] && (ad[0] == ad[1]);
        own = (hit && hitq) ? ownq : (setl[1] && !setl[0]);
        los[0] = hit && own;
        los[1] = hit && !own;
        for (int i = 0; i < 2; i++) begin
            wreq[i] = act[i] && !rw[i];
            rreq[i] = act[i] && rw[i];
            hold[i] = los[i] && lq[i] && !ceq[i] && (ad[i] == adq[i]) && rw[i] && rwq[i];
            wr[i]   = pd[i] && !wreq[i];
            nr[i] = rq[i]; nk[i] = rk[i];
            if (rreq[i] && !hold[i]) begin nr[i] = mm[ad[i]]; nk[i] = kn[ad[i]]; end
        end
        if (wr[1]) begin mm[pa[1]] = pdat[1]; kn[pa[1]] = 1; end
        if (wr[0]) begin mm[pa[0]] = pdat[0]; kn[pa[0]] = 1; end
        for (int i = 0; i < 2; i++) begin
            if (wreq[i] && !los[i]) begin pd[i] = 1; pa[i] = ad[i]; pdat[i] = wd[i]; end
            else pd[i] = 0;
            ceq[i] = ce[i]; rwq[i] = rw[i]; adq[i] = ad[i]; lq[i] = los[i];
            rq[i] = nr[i]; rk[i] = nk[i]; bz[i] = !los[i];
        end
        hitq = hit; ownq = own;
        @(posedge clk); #1;
        chk({7'd0, a_busy_n}, {7'd0, bz[0]}, {tag, " model busy A"});
        chk({7'd0, b_busy_n}, {7'd0, bz[1]}, {tag, " model busy B"});
        if (rk[0]) chk(a_rdata, oe[0] ? 8'h00 : rq[0], {tag, " model rdata A"});
        if (rk[1]) chk(b_rdata, oe[1] ? 8'h00 : rq[1], {tag, " model rdata B"});
    endtask

    task automatic drive(input int p, input bit c, input bit r, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        ce[p] = c; rw[p] = r; ad[p] = a; wd[p] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            ce[i] = 1; rw[i] = 1; oe[i] = 0; ad[i] = '0; wd[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        model_reset();
        chk({7'd0, a_busy_n}, 8'd1, "R9 reset busy A");
        chk({7'd0, b_busy_n}, 8'd1, "R9 reset busy B");
        chk(a_rdata, 8'h00, "R9 reset rdata A");
        chk(b_rdata, 8'h00, "R9 reset rdata B");

        // Vector table: arbitration and BUSY timing.
        for (int v = 0; v < NV; v++) begin
            drive(0, VEC[v][9], VEC[v][8], AW'(16 + VEC[v][7:6]), 8'hA0 | 8'(v));
            drive(1, VEC[v][5], VEC[v][4], AW'(16 + VEC[v][3:2]), 8'hB0 | 8'(v));
            tick("R5");
            chk({7'd0, a_busy_n}, {7'd0, VEC[v][1]}, $sformatf("R3/R4/R5 table %0d busy A", v));
            chk({7'd0, b_busy_n}, {7'd0, VEC[v][0]}, $sformatf("R3/R4/R5 table %0d busy B", v));
        end

        // Same-word writes: A held the word, B's data committed afterwards.
        drive(0, 0, 1, 10'd19, 8'h00); drive(1, 1, 1, 10'd0, 8'h00);
        tick("R1");
        chk(a_rdata, 8'hBC, "R1 later commit visible");

        // Loser hold, blocked write, release on read/write toggle.
        drive(0, 1, 1, 10'd40, 8'h00); drive(1, 0, 0, 10'd40, 8'h55); tick("R1");
        drive(1, 1, 1, 10'd40, 8'h55); tick("R1");
        drive(1, 0, 0, 10'd40, 8'h77); tick("R5");
        drive(0, 0, 1, 10'd40, 8'h00); tick("R5");
        chk({7'd0, a_busy_n}, 8'd0, "R5 settled B owns word");
        chk(a_rdata, 8'h55, "R7 first loss reads memory");
        drive(1, 0, 1, 10'd40, 8'h77); tick("R7");
        chk(a_rdata, 8'h55, "R7 loser held after owner commit");
        tick("R7");
        chk(a_rdata, 8'h55, "R7 loser still held");
        chk(b_rdata, 8'h77, "R2 owner reads committed word");
        drive(0, 0, 0, 10'd40, 8'h99); tick("R6");
        chk({7'd0, a_busy_n}, 8'd0, "R6 writer still losing");
        drive(0, 0, 1, 10'd40, 8'h00); tick("R7");
        chk(a_rdata, 8'h77, "R7 refresh on read/write toggle");
        drive(0, 1, 1, 10'd40, 8'h00); drive(1, 1, 1, 10'd40, 8'h00); tick("R6");
        drive(0, 0, 1, 10'd40, 8'h00); tick("R6");
        chk(a_rdata, 8'h77, "R6 blocked write never landed");
        oe[0] = 1; tick("R8");
        chk(a_rdata, 8'h00, "R8 output enable high blanks data");
        oe[0] = 0; tick("R8");
        chk(a_rdata, 8'h77, "R8 held value returns");

        // Random two-port traffic on four shared words.
        for (int n = 0; n < NRAND; n++) begin
            for (int p = 0; p < 2; p++) begin
                drive(p, ($urandom % 4) == 0, $urandom % 2, AW'(16 + ($urandom % 4)),
                      8'($urandom));
                oe[p] = ($urandom % 10) == 0;
            end
            tick("R2 R3 R4 R5 R6 R7");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule